// File: doc/BRIEF.md
# Bus Idle Gap Controller

This block sits in front of the access sequencer of an external bus controller. It decides how many idle bus cycles must pass between the end of one external access and the start of the next. For each request it knows the target area (0 to 6), whether it is a read or a write, and whether it is a single-address DMA transfer. It also knows whether the target area uses a multiplexed address/data interface. It remembers the same attributes of the access that last finished.

The idle count comes from a 3-bit code in a small settings bank. There is one code for each area and one shared code for DMA. When either side of the boundary is a single-address DMA transfer, the DMA code is used. Otherwise the code of the area that was just left is used. Dual-address DMA transfers arrive with the single-address flag low and are timed like CPU accesses. A cycle counter starts when an access finishes. The request is granted only when that counter has reached the required gap.

The sequencer holds `req_valid` and the request attributes until it sees `ready` high at a clock edge; that edge is the grant. It later pulses `acc_done` for one cycle to mark the end of the access.

Top module: `bus_idle_gap`

## Requirements
- R1: An idle code maps to a gap length as follows: codes 0 to 3 give 0 to 3 idle cycles, and codes 4, 5, 6, 7 give 6, 9, 12, 15 idle cycles.
- R2: After reset every area code and the DMA code read back as 7, so a switch to another area inserts 15 idle cycles until software writes new codes. A write with `cfg_idx` 0 to 6 sets that area's code; `cfg_idx` 7 sets the DMA code.
- R3: The DMA code sets the gap when either the finished access or the requested access has `req_dma_single` high. Otherwise the code of the finished access's area sets the gap.
- R4: When the requested area differs from the finished one, the gap equals the selected code's cycle count. When it is the same area and the MPX rule of R5 does not apply, the gap is 0.
- R5: For a same-area request after a write to a multiplexed area, the gap is the code's count, but at least 1. A same-area request after a read of a multiplexed area gets a gap of 0.
- R6: An area switch where either side is multiplexed inserts at least 1 idle cycle, even when the selected code is 0.
- R7: The first request after reset is granted with no idle cycles.
- R8: `ready` is high only when no access is in flight and the cycles counted since the last `acc_done` are at least the required gap. `busy` goes high on the cycle after a grant and falls on the cycle after `acc_done`. The gap is counted from the first cycle after the `acc_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for one idle code |
| cfg_idx | input | 3 | Code to write: 0..6 area, 7 DMA |
| cfg_code | input | 3 | New idle code |
| req_valid | input | 1 | Next access is pending |
| req_area | input | 3 | Target area of the next access |
| req_write | input | 1 | Next access is a write |
| req_dma_single | input | 1 | Next access is a single-address DMA transfer |
| req_mpx | input | 1 | Target area uses a multiplexed address/data bus |
| acc_done | input | 1 | One-cycle pulse: current access finished |
| ready | output | 1 | Grant: the request is accepted on this edge |
| busy | output | 1 | An access is in flight |

## Verification
A wrong stored code, a wrong field choice or a missing MPX floor shows at the ports as a grant that comes early or late. The error appears on the very next request after the affected boundary, as a count of waiting cycles that differs from the expected gap by whole cycles. A stuck `busy` flag or a lost record of the finished access shows as a grant while an access is in flight, or as a request that never gets a grant. The bench therefore compares, for every request, the number of cycles `req_valid` waited with `ready` low against a gap it works out independently. It covers every pairing of read/write and CPU/DMA, same and different area, with and without MPX.

// File: rtl/bic_pkg.sv
package bic_pkg;

  localparam int AREA_W = 3;
  localparam int CODE_W = 3;

  // attributes of one external access
  typedef struct packed {
    logic [AREA_W-1:0] area;
    logic              wr;
    logic              dma;
    logic              mpx;
  } acc_t;

  // idle code -> idle cycles: linear up to 3, then steps of 3
  function automatic logic [3:0] idle_cycles_f(input logic [CODE_W-1:0] code);
    int v;
    v = int'(code);
    if (v > 3) v = 3 * (v - 2);
    return 4'(v);
  endfunction

endpackage

// File: rtl/bic_cfg_bank.sv
module bic_cfg_bank
  import bic_pkg::*;
#(
  parameter int NUM_AREAS = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr,
  input  logic [AREA_W-1:0]             cfg_idx,
  input  logic [CODE_W-1:0]             cfg_code,
  output logic [NUM_AREAS*CODE_W-1:0]   area_codes,
  output logic [CODE_W-1:0]             dma_code
);

  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [AREA_W-1:0] DMA_IDX  = AREA_W'(NUM_AREAS);

  generate
    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
      logic [CODE_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   code_q <= CODE_MAX;
        else if (cfg_wr && cfg_idx == AREA_W'(g))     code_q <= cfg_code;
      end
      assign area_codes[g*CODE_W +: CODE_W] = code_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          dma_code <= CODE_MAX;
    else if (cfg_wr && cfg_idx == DMA_IDX) dma_code <= cfg_code;
  end

  // R2: a written code is visible on the next cycle
  a_r2_dma_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_idx == DMA_IDX) |=> dma_code == $past(cfg_code));

endmodule

// File: rtl/bic_need_calc.sv
module bic_need_calc
  import bic_pkg::*;
#(
  parameter int NUM_AREAS = 7,
  parameter int CNT_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        have_prev,
  input  acc_t                        prev_acc,
  input  acc_t                        next_acc,
  input  logic [NUM_AREAS*CODE_W-1:0] area_codes,
  input  logic [CODE_W-1:0]           dma_code,
  output logic [CNT_W-1:0]            need,
  output logic                        dev_switch,
  output logic                        mpx_floor,
  output logic                        use_dma
);

  logic [CODE_W-1:0] sel_code;
  logic [CNT_W-1:0]  base_cnt;

  function automatic logic [CODE_W-1:0] pick_area_code(
      input logic [NUM_AREAS*CODE_W-1:0] codes, input logic [AREA_W-1:0] a);
    logic [CODE_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_AREAS; i++)
      if (a == AREA_W'(i)) r = codes[i*CODE_W +: CODE_W];
    return r;
  endfunction

  assign use_dma    = prev_acc.dma | next_acc.dma;
  assign sel_code   = use_dma ? dma_code : pick_area_code(area_codes, prev_acc.area);
  assign base_cnt   = CNT_W'(idle_cycles_f(sel_code));
  assign dev_switch = prev_acc.area != next_acc.area;
  // multiplexed bus needs at least one turnaround cycle
  assign mpx_floor  = dev_switch ? (prev_acc.mpx | next_acc.mpx)
                                 : (prev_acc.mpx & prev_acc.wr);

  always_comb begin
    if (!have_prev)                  need = '0;
    else if (!dev_switch && !mpx_floor) need = '0;
    else if (mpx_floor && base_cnt == '0) need = CNT_W'(1);
    else                             need = base_cnt;
  end

  // R6 / R5: turnaround floor is honoured
  a_r6_mpx_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (have_prev && mpx_floor) |-> need != '0);
  // R4: plain same-area access gets no gap
  a_r4_same_area_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (have_prev && !dev_switch && !(prev_acc.mpx && prev_acc.wr)) |-> need == '0);
  // R7: nothing to separate from before the first access
  a_r7_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !have_prev |-> need == '0);

endmodule

// File: rtl/bic_gap_timer.sv
module bic_gap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] elapsed
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  elapsed <= '0;
    else if (restart)            elapsed <= '0;
    else if (elapsed != CNT_MAX) elapsed <= elapsed + CNT_W'(1);
  end

  // R8: counter saturates and never wraps
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed == CNT_MAX && !restart) |=> elapsed == CNT_MAX);
  // R8: counting starts at zero after an access ends
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> elapsed == '0);

endmodule

// File: rtl/bus_idle_gap.sv
module bus_idle_gap
  import bic_pkg::*;
#(
  parameter int NUM_AREAS = 7,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [AREA_W-1:0] cfg_idx,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              req_valid,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  input  logic              req_dma_single,
  input  logic              req_mpx,
  input  logic              acc_done,
  output logic              ready,
  output logic              busy
);

  logic [NUM_AREAS*CODE_W-1:0] area_codes;
  logic [CODE_W-1:0]           dma_code;
  logic [CNT_W-1:0]            elapsed;
  logic [CNT_W-1:0]            need;
  logic                        dev_switch, mpx_floor, use_dma;
  logic                        have_prev;
  acc_t                        prev_acc, cur_acc, next_acc;
  logic                        grant, finish;

  assign next_acc = '{area: req_area, wr: req_write, dma: req_dma_single, mpx: req_mpx};
  assign ready    = !busy && (elapsed >= need);
  assign grant    = req_valid && ready;
  assign finish   = busy && acc_done;

  bic_cfg_bank #(.NUM_AREAS(NUM_AREAS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_code(cfg_code), .area_codes(area_codes), .dma_code(dma_code)
  );

  bic_need_calc #(.NUM_AREAS(NUM_AREAS), .CNT_W(CNT_W)) u_need (
    .clk(clk), .rst_n(rst_n), .have_prev(have_prev), .prev_acc(prev_acc),
    .next_acc(next_acc), .area_codes(area_codes), .dma_code(dma_code),
    .need(need), .dev_switch(dev_switch), .mpx_floor(mpx_floor), .use_dma(use_dma)
  );

  bic_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(finish), .elapsed(elapsed)
  );

  // in-flight tracking; attributes committed when the access ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      have_prev <= 1'b0;
      cur_acc   <= '0;
      prev_acc  <= '0;
    end else begin
      if (grant) begin
        busy    <= 1'b1;
        cur_acc <= next_acc;
      end else if (finish) begin
        busy      <= 1'b0;
        prev_acc  <= cur_acc;
        have_prev <= 1'b1;
      end
    end
  end

  // R8: no grant while an access is in flight
  a_r8_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready);
  // R8: a grant makes the block busy
  a_r8_busy_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> busy);
  // R8: end of access frees the block
  a_r8_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);
  // R7: before any access has ended, an idle block always grants
  a_r7_first_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!have_prev && !busy) |-> ready);
  // R3: the DMA field is chosen whenever a single-address DMA is involved
  a_r3_dma_select: assert property (@(posedge clk) disable iff (!rst_n)
    (have_prev && req_dma_single) |-> use_dma);

endmodule

// File: tb/test_bus_idle_gap.sv
module test_bus_idle_gap;
  import bic_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst_n, cfg_wr, req_valid, req_write, req_dma_single, req_mpx, acc_done;
  logic [2:0] cfg_idx, cfg_code, req_area;
  logic ready, busy;

  bus_idle_gap i_bus_idle_gap (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_code(cfg_code),
    .req_valid(req_valid), .req_area(req_area), .req_write(req_write),
    .req_dma_single(req_dma_single), .req_mpx(req_mpx), .acc_done(acc_done),
    .ready(ready), .busy(busy)
  );

  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  int wait_cnt = 0;
  bit done_flag = 0;

  int gap_tab[8] = '{0, 1, 2, 3, 6, 9, 12, 15};
  int code_m[8];
  bit m_have = 0; int m_area = 0; bit m_wr = 0, m_dma = 0, m_mpx = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected gap from the requirements
  function automatic int model_gap(int a, bit wr, bit dma, bit mpx, output string tag);
    int b, c;
    if (!m_have) begin tag = "R7 first access"; return 0; end
    c = (m_dma || dma) ? code_m[7] : code_m[m_area];
    b = gap_tab[c];
    tag = (m_dma || dma) ? "R3 dma field" : "R4 area field";
    if (m_area != a) begin
      if ((m_mpx || mpx) && b == 0) begin tag = "R6 mpx switch"; return 1; end
      return b;
    end
    if (m_mpx && m_wr) begin
      tag = "R5 mpx after write";
      return (b == 0) ? 1 : b;
    end
    tag = "R4 same area";
    return 0;
  endfunction

  // monitor: measures how long each request waited
  always @(posedge clk) begin
    if (rst_n && req_valid) begin
      if (!ready) wait_cnt++;
      else begin
        if (exp_q.size() == 0) check(0, "R8 unexpected grant", wait_cnt, -1);
        else begin
          int e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(wait_cnt == e, t, wait_cnt, e);
        end
        wait_cnt = 0;
      end
    end
  end

  // called at a falling edge; returns at a falling edge after the grant
  task automatic issue(int a, bit wr, bit dma, bit mpx, string force_tag = "");
    int e; string t;
    e = model_gap(a, wr, dma, mpx, t);
    if (force_tag != "") t = force_tag;
    exp_q.push_back(e); tag_q.push_back(t);
    req_valid = 1; req_area = 3'(a); req_write = wr; req_dma_single = dma; req_mpx = mpx;
    do @(posedge clk); while (!ready);
    @(negedge clk);
    req_valid = 0;
    check(busy == 1'b1, "R8 busy after grant", int'(busy), 1);
    check(ready == 1'b0, "R8 no ready while busy", int'(ready), 0);
    m_have = 1; m_area = a; m_wr = wr; m_dma = dma; m_mpx = mpx;
  endtask

  task automatic finish_acc();
    acc_done = 1;
    @(negedge clk);
    acc_done = 0;
  endtask

  task automatic cfg_set(int idx, int code);
    cfg_wr = 1; cfg_idx = 3'(idx); cfg_code = 3'(code);
    @(negedge clk);
    cfg_wr = 0;
    code_m[idx] = code;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    foreach (code_m[i]) code_m[i] = 7;
    rst_n = 0; cfg_wr = 0; cfg_idx = 0; cfg_code = 0; req_valid = 0;
    req_area = 0; req_write = 0; req_dma_single = 0; req_mpx = 0; acc_done = 0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R8 reset not busy", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);

    // R7 then R2: defaults give 15 on an area switch
    issue(0, 0, 0, 0);
    finish_acc();
    issue(1, 1, 0, 0, "R2 default code 15");
    cfg_set(3, 0); cfg_set(5, 3); cfg_set(7, 2);
    finish_acc();

    // full sweep of boundary types
    for (int pm = 0; pm < 2; pm++)
      for (int pw = 0; pw < 2; pw++)
        for (int pd = 0; pd < 2; pd++)
          for (int nw = 0; nw < 2; nw++)
            for (int nd = 0; nd < 2; nd++)
              for (int sa = 0; sa < 2; sa++) begin
                issue(3, pw[0], pd[0], pm[0]);
                finish_acc();
                issue(sa ? 3 : 5, nw[0], nd[0], pm[0]);
                finish_acc();
              end

    // R1: every code value
    for (int c = 0; c < 8; c++) begin
      issue(2, 0, 0, 0);
      cfg_set(2, c);
      finish_acc();
      issue(6, 0, 0, 0, $sformatf("R1 code %0d", c));
      finish_acc();
    end

    // R6 / R5 with zero code on a multiplexed area
    issue(4, 1, 0, 1);
    cfg_set(4, 0);
    finish_acc();
    issue(4, 0, 0, 1, "R5 mpx write floor");
    finish_acc();
    issue(5, 0, 0, 1, "R6 mpx switch floor");
    finish_acc();
    issue(5, 0, 0, 1, "R5 mpx after read");
    finish_acc();

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R8 all requests granted", exp_q.size(), 0);
    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule